// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block forms the 16-bit effective address of a memory operand for an 8-bit processor core. It takes the operand bytes of the current instruction, the two index registers, and any pointer bytes already fetched from memory. It then produces the operand address and the addresses the sequencer must use to fetch a pointer. It also tells the sequencer whether the access needs one more bus cycle, and which address that cycle should touch.

Every input is captured on a cycle with `calc_en` high. The results appear on registered outputs one clock later and hold until the next capture. The parameter `CMOS_FIX` selects one of two variants:
- With `CMOS_FIX` = 0, the older behaviour is kept. An indirect jump wraps its pointer inside one page. The extra cycle on a page crossing does a dummy read at the address whose high byte is not yet corrected.
- With `CMOS_FIX` = 1, the indirect-jump pointer carries into the next page and always costs one cycle. A page-crossing dummy cycle re-reads the last instruction byte.

Top module: `ea_gen`

## Requirements
- R1: While reset is held, and afterwards until the first capture, every output is zero.
- R2: When `calc_en` is high at a clock edge, the outputs reflect the captured inputs after that edge. When `calc_en` is low, every output holds its value, whatever the other inputs do.
- R3: The zero-page modes are selected by `mode` values 0 (no index), 1 (plus X) and 2 (plus Y). In these modes `ea` is {8'h00, (opnd_lo + index) mod 256}, and `page_cross` and `extra_cycle` are 0.
- R4: Mode 3 (absolute) gives `ea` = {opnd_hi, opnd_lo}. Mode 4 (absolute plus X) and mode 5 (absolute plus Y) give `ea` = ({opnd_hi, opnd_lo} + index) mod 65536.
- R5: `page_cross` is 1 exactly when, in modes 4, 5 or 7, the addition of the index to the low base byte carries out of 8 bits. In every other mode it is 0.
- R6: In modes 4, 5 and 7, `extra_cycle` is 1 if `page_cross` is 1 or if `acc_kind` is non-zero. The `acc_kind` codes are 0 read, 1 store and 2 read-modify-write.
- R7: Mode 6 (pre-indexed indirect) gives `ptr_lo_addr` = {8'h00, z} and `ptr_hi_addr` = {8'h00, (z+1) mod 256}, with z = (opnd_lo + X) mod 256. It gives `ea` = {ptr_hi, ptr_lo}.
- R8: Mode 7 (post-indexed indirect) gives `ptr_lo_addr` = {8'h00, opnd_lo} and `ptr_hi_addr` = {8'h00, (opnd_lo+1) mod 256}. It gives `ea` = ({ptr_hi, ptr_lo} + Y) mod 65536.
- R9: Mode 8 (indirect jump) gives `ptr_lo_addr` = {opnd_hi, opnd_lo} and `ea` = {ptr_hi, ptr_lo}. With `CMOS_FIX` = 0, `ptr_hi_addr` = {opnd_hi, (opnd_lo+1) mod 256} and `extra_cycle` = 0. With `CMOS_FIX` = 1, `ptr_hi_addr` = {opnd_hi, opnd_lo} + 1 and `extra_cycle` = 1.
- R10: `dummy_addr` is 0 whenever `extra_cycle` is 0. With `CMOS_FIX` = 0, an indexed extra cycle uses {base_hi, low-byte sum}. With `CMOS_FIX` = 1, it uses `last_byte_addr` when a page is crossed and the final `ea` otherwise. A mode 8 extra cycle uses `last_byte_addr`.
- R11: In modes 0 to 5, the pointer address outputs are 0. Mode values 9 to 15 give all outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| calc_en | input | 1 | Capture strobe for a new address computation |
| mode | input | 4 | Addressing mode code (0..8) |
| acc_kind | input | 2 | Access kind: 0 read, 1 store, 2 read-modify-write |
| opnd_lo | input | 8 | First operand byte |
| opnd_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| ptr_lo | input | 8 | Pointer low byte fetched from memory |
| ptr_hi | input | 8 | Pointer high byte fetched from memory |
| last_byte_addr | input | 16 | Address of the last instruction byte fetched |
| ea | output | 16 | Effective address |
| ptr_lo_addr | output | 16 | Address of the pointer low byte |
| ptr_hi_addr | output | 16 | Address of the pointer high byte |
| page_cross | output | 1 | Low-byte index addition carried into the high byte |
| extra_cycle | output | 1 | Sequencer must insert one more cycle |
| dummy_addr | output | 16 | Address for the bus access in the extra cycle |

## Verification
The bench targets wrap points:
- A zero-page index from $FF that must return to $00, not reach $0100. A design that propagates the carry would output an address in page 1.
- A zero-page pointer whose high byte sits at $00.
- An absolute index that runs past $FFFF.
- An indirect-jump pointer ending in $FF. A design that mixes up the variants would fetch the high byte from $1900 instead of $2000, or the reverse.

It also checks stores and read-modify-writes that cross no page but must still request the extra cycle. Both variants run side by side, so a swapped dummy address shows up as a mismatch on the first crossing read.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [3:0] {
    AM_ZP   = 4'd0,
    AM_ZPX  = 4'd1,
    AM_ZPY  = 4'd2,
    AM_ABS  = 4'd3,
    AM_ABSX = 4'd4,
    AM_ABSY = 4'd5,
    AM_INDX = 4'd6,
    AM_INDY = 4'd7,
    AM_JIND = 4'd8
  } am_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_RMW   = 2'd2
  } acc_e;

  // Modes whose base is indexed by a full 16-bit add with a low-byte carry
  function automatic logic is_long_indexed(input am_e m);
    return (m == AM_ABSX) || (m == AM_ABSY) || (m == AM_INDY);
  endfunction

endpackage

// File: rtl/ea_rst_sync.sv
module ea_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ea_zp_wrap.sv
module ea_zp_wrap #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] idx,
  output logic [DW-1:0] loc0,
  output logic [DW-1:0] loc1
);

  // Both sums stay DW wide, so the page number can never leave zero
  always_comb begin
    loc0 = base + idx;
    loc1 = loc0 + {{(DW-1){1'b0}}, 1'b1};
  end

endmodule

// File: rtl/ea_index_add.sv
module ea_index_add #(
  parameter int DW = 8
) (
  input  logic [DW-1:0]   base_hi,
  input  logic [DW-1:0]   base_lo,
  input  logic [DW-1:0]   idx,
  output logic            lo_carry,
  output logic [2*DW-1:0] full_sum,
  output logic [2*DW-1:0] uncorr_sum
);

  logic [DW:0]   lo_ext;
  logic [DW-1:0] hi_fixed;

  always_comb begin
    lo_ext     = {1'b0, base_lo} + {1'b0, idx};
    lo_carry   = lo_ext[DW];
    hi_fixed   = base_hi + {{(DW-1){1'b0}}, lo_ext[DW]};
    full_sum   = {hi_fixed, lo_ext[DW-1:0]};
    uncorr_sum = {base_hi, lo_ext[DW-1:0]};
  end

endmodule

// File: rtl/ea_variant.sv
module ea_variant #(
  parameter int DW       = 8,
  parameter bit CMOS_FIX = 1'b0,
  localparam int AW      = 2 * DW
) (
  input  logic [DW-1:0] jmp_hi,
  input  logic [DW-1:0] jmp_lo,
  input  logic          is_indexed,
  input  logic          is_jind,
  input  logic          idx_extra,
  input  logic          idx_cross,
  input  logic [AW-1:0] idx_full,
  input  logic [AW-1:0] idx_uncorr,
  input  logic [AW-1:0] last_addr,
  output logic [AW-1:0] jmp_hi_addr,
  output logic          jmp_extra,
  output logic [AW-1:0] dummy
);

  logic [AW-1:0] idx_dummy;
  logic [AW-1:0] jind_dummy;

  generate
    if (CMOS_FIX) begin : g_fixed
      // Pointer high byte carries into the next page; one cycle is paid
      assign jmp_hi_addr = {jmp_hi, jmp_lo} + {{(AW-1){1'b0}}, 1'b1};
      assign jmp_extra   = 1'b1;
    end else begin : g_legacy
      // Low pointer byte wraps inside its page; no extra cycle
      assign jmp_hi_addr = {jmp_hi, jmp_lo + {{(DW-1){1'b0}}, 1'b1}};
      assign jmp_extra   = 1'b0;
    end
  endgenerate

  always_comb begin
    if (CMOS_FIX) begin
      idx_dummy  = idx_cross ? last_addr : idx_full;
      jind_dummy = last_addr;
    end else begin
      idx_dummy  = idx_uncorr;
      jind_dummy = '0;
    end
    dummy = '0;
    if (is_indexed && idx_extra) dummy = idx_dummy;
    else if (is_jind)            dummy = jind_dummy;
  end

endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int DW          = 8,
  parameter bit CMOS_FIX    = 1'b0,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          calc_en,
  input  logic [3:0]    mode,
  input  logic [1:0]    acc_kind,
  input  logic [DW-1:0] opnd_lo,
  input  logic [DW-1:0] opnd_hi,
  input  logic [DW-1:0] idx_x,
  input  logic [DW-1:0] idx_y,
  input  logic [DW-1:0] ptr_lo,
  input  logic [DW-1:0] ptr_hi,
  input  logic [AW-1:0] last_byte_addr,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] ptr_lo_addr,
  output logic [AW-1:0] ptr_hi_addr,
  output logic          page_cross,
  output logic          extra_cycle,
  output logic [AW-1:0] dummy_addr
);

  localparam logic [DW-1:0] ZERO_PAGE = '0;

  logic rst_core_n;

  ea_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  am_e m;
  assign m = am_e'(mode);

  // Operand selection for the two arithmetic paths
  logic [DW-1:0] zp_idx, lx_idx, lx_base_hi, lx_base_lo;
  logic          in_long, in_jind;

  always_comb begin
    unique case (m)
      AM_ZPX, AM_INDX: zp_idx = idx_x;
      AM_ZPY:          zp_idx = idx_y;
      default:         zp_idx = '0;
    endcase
    unique case (m)
      AM_ABSX:         lx_idx = idx_x;
      AM_ABSY, AM_INDY: lx_idx = idx_y;
      default:         lx_idx = '0;
    endcase
    lx_base_hi = (m == AM_INDY) ? ptr_hi : opnd_hi;
    lx_base_lo = (m == AM_INDY) ? ptr_lo : opnd_lo;
    in_long    = is_long_indexed(m);
    in_jind    = (m == AM_JIND);
  end

  logic [DW-1:0] zp_loc0, zp_loc1;

  ea_zp_wrap #(.DW(DW)) u_zp (
    .base (opnd_lo),
    .idx  (zp_idx),
    .loc0 (zp_loc0),
    .loc1 (zp_loc1)
  );

  logic          lx_carry;
  logic [AW-1:0] lx_full, lx_uncorr;

  ea_index_add #(.DW(DW)) u_idx (
    .base_hi    (lx_base_hi),
    .base_lo    (lx_base_lo),
    .idx        (lx_idx),
    .lo_carry   (lx_carry),
    .full_sum   (lx_full),
    .uncorr_sum (lx_uncorr)
  );

  logic          lx_extra;
  assign lx_extra = lx_carry || (acc_e'(acc_kind) != ACC_READ);

  logic [AW-1:0] jmp_hi_addr, var_dummy;
  logic          jmp_extra;

  ea_variant #(.DW(DW), .CMOS_FIX(CMOS_FIX)) u_var (
    .jmp_hi      (opnd_hi),
    .jmp_lo      (opnd_lo),
    .is_indexed  (in_long),
    .is_jind     (in_jind),
    .idx_extra   (lx_extra),
    .idx_cross   (lx_carry),
    .idx_full    (lx_full),
    .idx_uncorr  (lx_uncorr),
    .last_addr   (last_byte_addr),
    .jmp_hi_addr (jmp_hi_addr),
    .jmp_extra   (jmp_extra),
    .dummy       (var_dummy)
  );

  // Next-state values
  logic [AW-1:0] ea_d, pl_d, ph_d, dm_d;
  logic          pc_d, ex_d;

  always_comb begin
    ea_d = '0;
    pl_d = '0;
    ph_d = '0;
    pc_d = 1'b0;
    ex_d = 1'b0;
    dm_d = var_dummy;
    unique case (m)
      AM_ZP, AM_ZPX, AM_ZPY: begin
        ea_d = {ZERO_PAGE, zp_loc0};
      end
      AM_ABS: begin
        ea_d = {opnd_hi, opnd_lo};
      end
      AM_ABSX, AM_ABSY: begin
        ea_d = lx_full;
        pc_d = lx_carry;
        ex_d = lx_extra;
      end
      AM_INDY: begin
        pl_d = {ZERO_PAGE, zp_loc0};
        ph_d = {ZERO_PAGE, zp_loc1};
        ea_d = lx_full;
        pc_d = lx_carry;
        ex_d = lx_extra;
      end
      AM_INDX: begin
        pl_d = {ZERO_PAGE, zp_loc0};
        ph_d = {ZERO_PAGE, zp_loc1};
        ea_d = {ptr_hi, ptr_lo};
      end
      AM_JIND: begin
        pl_d = {opnd_hi, opnd_lo};
        ph_d = jmp_hi_addr;
        ea_d = {ptr_hi, ptr_lo};
        ex_d = jmp_extra;
      end
      default: begin
        dm_d = '0;
      end
    endcase
  end

  // Output registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ea          <= '0;
      ptr_lo_addr <= '0;
      ptr_hi_addr <= '0;
      page_cross  <= 1'b0;
      extra_cycle <= 1'b0;
      dummy_addr  <= '0;
    end else if (calc_en) begin
      ea          <= ea_d;
      ptr_lo_addr <= pl_d;
      ptr_hi_addr <= ph_d;
      page_cross  <= pc_d;
      extra_cycle <= ex_d;
      dummy_addr  <= dm_d;
    end
  end

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int DW       = 8,
  parameter bit CMOS_FIX = 1'b0,
  localparam int AW      = 2 * DW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          calc_en,
  input logic [3:0]    mode,
  input logic [1:0]    acc_kind,
  input logic [DW-1:0] opnd_hi,
  input logic [AW-1:0] ea,
  input logic [AW-1:0] ptr_lo_addr,
  input logic [AW-1:0] ptr_hi_addr,
  input logic          page_cross,
  input logic          extra_cycle,
  input logic [AW-1:0] dummy_addr
);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !calc_en |=> ($stable(ea) && $stable(ptr_lo_addr) && $stable(ptr_hi_addr)
                  && $stable(page_cross) && $stable(extra_cycle) && $stable(dummy_addr)));

  a_r3_zp_stays_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    (calc_en && mode <= 4'd2) |=> (ea[AW-1:DW] == '0 && !page_cross && !extra_cycle));

  a_r6_cross_costs_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    page_cross |-> extra_cycle);

  a_r6_write_costs_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (calc_en && acc_kind != 2'd0 && (mode == 4'd4 || mode == 4'd5 || mode == 4'd7))
      |=> extra_cycle);

  a_r7_ptr_in_zero_page: assert property (@(posedge clk) disable iff (!rst_n)
    (calc_en && (mode == 4'd6 || mode == 4'd7)) |=>
      (ptr_lo_addr[AW-1:DW] == '0 && ptr_hi_addr[AW-1:DW] == '0
       && ptr_hi_addr[DW-1:0] == ptr_lo_addr[DW-1:0] + 1'b1));

  a_r9_jump_pointer: assert property (@(posedge clk) disable iff (!rst_n)
    (calc_en && mode == 4'd8) |=>
      (CMOS_FIX ? (ptr_hi_addr == ptr_lo_addr + 1'b1 && extra_cycle)
                : (ptr_hi_addr[AW-1:DW] == $past(opnd_hi) && !extra_cycle)));

  a_r10_no_dummy_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !extra_cycle |-> dummy_addr == '0);

endmodule

bind ea_gen ea_gen_chk #(.DW(DW), .CMOS_FIX(CMOS_FIX)) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .calc_en     (calc_en),
  .mode        (mode),
  .acc_kind    (acc_kind),
  .opnd_hi     (opnd_hi),
  .ea          (ea),
  .ptr_lo_addr (ptr_lo_addr),
  .ptr_hi_addr (ptr_hi_addr),
  .page_cross  (page_cross),
  .extra_cycle (extra_cycle),
  .dummy_addr  (dummy_addr)
);

// File: tb/sim_ea_gen.sv
`timescale 1ns/1ps
module sim_ea_gen;

  typedef struct packed {
    logic [15:0] ea;
    logic [15:0] pl;
    logic [15:0] ph;
    logic [15:0] dm;
    logic        pc;
    logic        ex;
  } res_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        calc_en = 1'b0;
  logic [3:0]  mode = '0;
  logic [1:0]  acc_kind = '0;
  logic [7:0]  opnd_lo = '0, opnd_hi = '0, idx_x = '0, idx_y = '0, ptr_lo = '0, ptr_hi = '0;
  logic [15:0] last_byte_addr = '0;

  logic [15:0] ea0, pl0, ph0, dm0, ea1, pl1, ph1, dm1;
  logic        pc0, ex0, pc1, ex1;

  ea_gen #(.CMOS_FIX(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .calc_en(calc_en), .mode(mode), .acc_kind(acc_kind),
    .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .idx_x(idx_x), .idx_y(idx_y),
    .ptr_lo(ptr_lo), .ptr_hi(ptr_hi), .last_byte_addr(last_byte_addr),
    .ea(ea0), .ptr_lo_addr(pl0), .ptr_hi_addr(ph0), .page_cross(pc0),
    .extra_cycle(ex0), .dummy_addr(dm0));

  ea_gen #(.CMOS_FIX(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .calc_en(calc_en), .mode(mode), .acc_kind(acc_kind),
    .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .idx_x(idx_x), .idx_y(idx_y),
    .ptr_lo(ptr_lo), .ptr_hi(ptr_hi), .last_byte_addr(last_byte_addr),
    .ea(ea1), .ptr_lo_addr(pl1), .ptr_hi_addr(ph1), .page_cross(pc1),
    .extra_cycle(ex1), .dummy_addr(dm1));

  res_t act0, act1, exp0, exp1, nxt0, nxt1;
  assign act0 = {ea0, pl0, ph0, dm0, pc0, ex0};
  assign act1 = {ea1, pl1, ph1, dm1, pc1, ex1};

  int    checks = 0;
  int    fails = 0;
  bit    pend = 1'b0;
  bit    done = 1'b0;
  string pend_tag = "R1";
  string idle_tag = "R1";

  function automatic res_t model(input bit cm, input int m, input int k, input int lo,
                                 input int hi, input int x, input int y, input int plo,
                                 input int phi, input int last);
    res_t r;
    int bh, bl, ix, z;
    r = '0;
    case (m)
      0: r.ea = 16'(lo);
      1: r.ea = 16'((lo + x) % 256);
      2: r.ea = 16'((lo + y) % 256);
      3: r.ea = 16'(hi * 256 + lo);
      4, 5, 7: begin
        bh = (m == 7) ? phi : hi;
        bl = (m == 7) ? plo : lo;
        ix = (m == 4) ? x : y;
        r.ea = 16'((bh * 256 + bl + ix) % 65536);
        r.pc = (bl + ix) > 255;
        r.ex = r.pc || (k != 0);
        if (r.ex) r.dm = (cm && r.pc) ? 16'(last) : 16'(bh * 256 + (bl + ix) % 256);
        if (m == 7) begin
          r.pl = 16'(lo);
          r.ph = 16'((lo + 1) % 256);
        end
      end
      6: begin
        z = (lo + x) % 256;
        r.pl = 16'(z);
        r.ph = 16'((z + 1) % 256);
        r.ea = 16'(phi * 256 + plo);
      end
      8: begin
        r.pl = 16'(hi * 256 + lo);
        r.ph = cm ? 16'((hi * 256 + lo + 1) % 65536) : 16'(hi * 256 + (lo + 1) % 256);
        r.ea = 16'(phi * 256 + plo);
        r.ex = cm;
        r.dm = cm ? 16'(last) : 16'h0000;
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (act0 !== exp0) begin
      fails++;
      $display("FAIL %s u0 (legacy): got %h expected %h", tag, act0, exp0);
    end
    checks++;
    if (act1 !== exp1) begin
      fails++;
      $display("FAIL %s u1 (fixed): got %h expected %h", tag, act1, exp1);
    end
  endtask

  task automatic step(input string tag, input bit en, input int m, input int k,
                      input int lo, input int hi, input int x, input int y,
                      input int plo, input int phi, input int last);
    @(negedge clk);
    if (pend) begin
      exp0 = nxt0;
      exp1 = nxt1;
      compare(pend_tag);
      idle_tag = "R2";
    end else begin
      compare(idle_tag);
    end
    pend = 1'b0;
    calc_en = en;
    mode = 4'(m);
    acc_kind = 2'(k);
    opnd_lo = 8'(lo);
    opnd_hi = 8'(hi);
    idx_x = 8'(x);
    idx_y = 8'(y);
    ptr_lo = 8'(plo);
    ptr_hi = 8'(phi);
    last_byte_addr = 16'(last);
    if (en) begin
      nxt0 = model(1'b0, m, k, lo, hi, x, y, plo, phi, last);
      nxt1 = model(1'b1, m, k, lo, hi, x, y, plo, phi, last);
      pend = 1'b1;
      pend_tag = tag;
    end
  endtask

  function automatic string tag_of(input int m);
    case (m)
      0, 1, 2: return "R3";
      3, 4, 5: return "R4";
      6:       return "R7";
      7:       return "R8";
      8:       return "R9";
      default: return "R11";
    endcase
  endfunction

  initial begin
    exp0 = '0;
    exp1 = '0;
    repeat (3) @(negedge clk);
    compare("R1");                     // outputs cleared while reset is held
    rst_n = 1'b1;
    repeat (4) step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R3: zero-page forms, including wrap at $FF
    step("R3", 1, 0, 0, 'h42, 'h99, 0, 0, 0, 0, 0);
    step("R3", 1, 1, 0, 'hFF, 'h12, 'h01, 0, 0, 0, 0);
    step("R3", 1, 2, 1, 'h80, 0, 0, 'h90, 0, 0, 0);
    // R4 / R5 / R6: absolute forms
    step("R4", 1, 3, 0, 'h34, 'h12, 'h55, 'h66, 0, 0, 0);
    step("R5", 1, 4, 0, 'h34, 'h12, 'h10, 0, 0, 0, 'h0802);
    step("R10", 1, 4, 0, 'hF0, 'h12, 'h20, 0, 0, 0, 'h0802);
    step("R6", 1, 5, 1, 'h10, 'h40, 0, 'h05, 0, 0, 'h0903);
    step("R6", 1, 4, 2, 'hFF, 'hFF, 'h01, 0, 0, 0, 'h0A04);
    // R7: pre-indexed pointer straddling $FF/$00
    step("R7", 1, 6, 0, 'hFE, 'h77, 'h01, 0, 'h34, 'h12, 0);
    // R8: post-indexed with pointer at $FF and a crossing read
    step("R8", 1, 7, 0, 'hFF, 0, 0, 'h20, 'hF0, 'h20, 'h0B05);
    step("R8", 1, 7, 1, 'h10, 0, 0, 'h01, 'h00, 'h30, 'h0B05);
    // R9: indirect jump at the page end and in mid-page
    step("R9", 1, 8, 0, 'hFF, 'h19, 0, 0, 'hCD, 'hAB, 'h0C06);
    step("R9", 1, 8, 0, 'h10, 'h19, 0, 0, 'h00, 'h80, 'h0C06);
    // R11: unused mode codes
    step("R11", 1, 9, 0, 'hFF, 'hFF, 'hFF, 'hFF, 'hFF, 'hFF, 'hFFFF);
    step("R11", 1, 15, 1, 'h11, 'h22, 'h33, 'h44, 'h55, 'h66, 'h7777);
    // R2: capture, then no capture while inputs change
    step("R2", 1, 4, 0, 'hF8, 'h21, 'h10, 0, 0, 0, 'h1234);
    step("R2", 0, 8, 2, 'h01, 'h02, 'h03, 'h04, 'h05, 'h06, 'h0007);
    step("R2", 0, 1, 1, 'hAA, 'hBB, 'hCC, 'hDD, 'hEE, 'hFF, 'h1111);
    // Mixed sequence across all modes
    for (int i = 0; i < 400; i++) begin
      int m;
      m = $urandom_range(0, 9);
      step(tag_of(m), ($urandom_range(0, 3) != 0), m, $urandom_range(0, 2),
           $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255),
           $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255),
           $urandom_range(0, 65535));
    end
    step("R2", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule